// File: doc/BRIEF.md
# Issue Window Select Arbiter Tree

This block decides which ready entries of an issue window are handed to functional units in the current cycle. Each window slot raises a request bit. The requests feed a tree of small fixed-priority arbiter nodes. Every node reports upward whether any request below it is active. Grants flow back down from the root. A node may pass a grant to one of its children only if its own parent has enabled it. The root of each tree is enabled only when the functional unit that the tree serves is free. Among the active requests, the slot with the lowest index always wins.

Several functional units of the same type are served by placing one select tree per unit in series. Unit 0's tree sees the raw requests. Each later tree sees the requests that remain after the earlier trees have removed their grants. The selection is purely combinational from the requests and the unit-available inputs. A registered copy of every grant vector and valid bit is also provided for the next pipeline stage.

No state machine is needed. The block's only state is the output pipeline register. It is cleared while `rst_n` is low and otherwise loads the combinational grants on every rising clock edge.

Top module: `issue_select_tree`

## Requirements
- R1: Each unit's grant vector `gnt[u]` has at most one bit set.
- R2: Every set bit of any grant vector corresponds to a set bit of `req`.
- R3: When `fu_avail[0]` is 1 and `req` is nonzero, `gnt[0]` has exactly the lowest-indexed set bit of `req` (bit i stands for window slot i).
- R4: When `fu_avail[u]` is 0, `gnt[u]` is all zero and `vld[u]` is 0, whatever the requests are.
- R5: When `fu_avail[1]` is 1, `gnt[1]` has the lowest-indexed set bit of `req & ~gnt[0]`. With unit 0 busy, this is the lowest request. With unit 0 free, it is the second-lowest request.
- R6: `gnt[0]` and `gnt[1]` never have a set bit in common.
- R7: `vld[u]` is 1 exactly when `gnt[u]` is nonzero.
- R8: At each rising clock edge with `rst_n` high, `gnt_q` and `vld_q` take the values of `gnt` and `vld`. While `rst_n` is low, `gnt_q` and `vld_q` are zero.
- R9: When `req` is all zero, every grant vector is zero and every valid bit is 0, even with all units available.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| req | input | WIN | Ready request per window slot; bit i is slot i |
| fu_avail | input | NUM_FU | Unit u is free this cycle; enables the root of tree u |
| gnt | output | NUM_FU x WIN | Combinational one-hot grant vector per unit |
| vld | output | NUM_FU | Combinational grant-valid per unit |
| gnt_q | output | NUM_FU x WIN | Registered copy of `gnt` |
| vld_q | output | NUM_FU | Registered copy of `vld` |

## Verification
The bench builds the block with its defaults: a 32-entry window, 4-input nodes and two chained units. With these values the tree has three levels, and 32 pad slots sit above the real window inside the top-level node. Slots at node edges, such as 3/4, 15/16 and 31, move the winner between subtrees and are driven directly. Sparse and dense random request patterns, combined with every unit-available combination, exercise the masking of unit 0's grant from unit 1's tree in both the free and the busy case for unit 0.

// File: rtl/sel_pkg.sv
package sel_pkg;

    // Number of tree levels needed so that radix**levels >= entries.
    function automatic int unsigned levels_for(input int unsigned entries,
                                               input int unsigned radix);
        int unsigned span;
        int unsigned lv;
        span = radix;
        lv   = 1;
        while (span < entries) begin
            span = span * radix;
            lv   = lv + 1;
        end
        return lv;
    endfunction

endpackage

// File: rtl/sel_node.sv
module sel_node #(
    parameter int unsigned RADIX = 4
) (
    input  logic [RADIX-1:0] req_in,
    input  logic             enable,
    output logic             any_req,
    output logic [RADIX-1:0] gnt_out
);

    logic [RADIX:0] seen;

    // Fixed priority: child 0 wins over child 1, and so on.
    always_comb begin
        seen[0] = 1'b0;
        for (int i = 0; i < RADIX; i++) begin
            gnt_out[i] = enable & req_in[i] & ~seen[i];
            seen[i+1]  = seen[i] | req_in[i];
        end
        any_req = seen[RADIX];
    end

endmodule

// File: rtl/sel_tree.sv
module sel_tree #(
    parameter int unsigned WIN   = 32,
    parameter int unsigned RADIX = 4
) (
    input  logic [WIN-1:0] req,
    input  logic           root_en,
    output logic [WIN-1:0] gnt,
    output logic           any_req
);

    localparam int unsigned LEVELS = sel_pkg::levels_for(WIN, RADIX);
    localparam int unsigned PAD    = RADIX ** LEVELS;

    // up[l]: request bits entering level l; dn[l]: enables leaving level l.
    logic [LEVELS:0][PAD-1:0] up;
    logic [LEVELS:0][PAD-1:0] dn;

    assign up[0]          = PAD'(req);
    assign dn[LEVELS][0]  = root_en;

    for (genvar l = 0; l < LEVELS; l++) begin : g_level
        localparam int unsigned NN = PAD / (RADIX ** (l + 1));
        for (genvar n = 0; n < NN; n++) begin : g_node
            sel_node #(.RADIX(RADIX)) u_node (
                .req_in  (up[l][n*RADIX +: RADIX]),
                .enable  (dn[l+1][n]),
                .any_req (up[l+1][n]),
                .gnt_out (dn[l][n*RADIX +: RADIX])
            );
        end
        if (NN < PAD) begin : g_pad
            assign up[l+1][PAD-1:NN] = '0;
            assign dn[l+1][PAD-1:NN] = '0;
        end
    end

    assign gnt     = dn[0][WIN-1:0];
    assign any_req = up[LEVELS][0];

endmodule

// File: rtl/sel_grant_reg.sv
module sel_grant_reg #(
    parameter int unsigned WIN    = 32,
    parameter int unsigned NUM_FU = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_FU-1:0][WIN-1:0]   d_gnt,
    input  logic [NUM_FU-1:0]            d_vld,
    output logic [NUM_FU-1:0][WIN-1:0]   q_gnt,
    output logic [NUM_FU-1:0]            q_vld
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_gnt <= '0;
            q_vld <= '0;
        end else begin
            q_gnt <= d_gnt;
            q_vld <= d_vld;
        end
    end

endmodule

// File: rtl/issue_select_tree.sv
module issue_select_tree #(
    parameter int unsigned WIN    = 32,
    parameter int unsigned RADIX  = 4,
    parameter int unsigned NUM_FU = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [WIN-1:0]             req,
    input  logic [NUM_FU-1:0]          fu_avail,
    output logic [NUM_FU-1:0][WIN-1:0] gnt,
    output logic [NUM_FU-1:0]          vld,
    output logic [NUM_FU-1:0][WIN-1:0] gnt_q,
    output logic [NUM_FU-1:0]          vld_q
);

    // remain[u]: requests still open when tree u makes its choice.
    logic [NUM_FU:0][WIN-1:0] remain;
    logic [NUM_FU-1:0]        tree_any;

    assign remain[0] = req;

    for (genvar u = 0; u < NUM_FU; u++) begin : g_unit
        sel_tree #(.WIN(WIN), .RADIX(RADIX)) u_tree (
            .req     (remain[u]),
            .root_en (fu_avail[u]),
            .gnt     (gnt[u]),
            .any_req (tree_any[u])
        );
        assign vld[u]      = tree_any[u] & fu_avail[u];
        assign remain[u+1] = remain[u] & ~gnt[u];
    end

    sel_grant_reg #(.WIN(WIN), .NUM_FU(NUM_FU)) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .d_gnt (gnt),
        .d_vld (vld),
        .q_gnt (gnt_q),
        .q_vld (vld_q)
    );

endmodule

// File: rtl/issue_select_tree_chk.sv
module issue_select_tree_chk #(
    parameter int unsigned WIN    = 32,
    parameter int unsigned NUM_FU = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [WIN-1:0]             req,
    input logic [NUM_FU-1:0]          fu_avail,
    input logic [NUM_FU-1:0][WIN-1:0] gnt,
    input logic [NUM_FU-1:0]          vld,
    input logic [NUM_FU-1:0][WIN-1:0] gnt_q,
    input logic [NUM_FU-1:0]          vld_q
);

    for (genvar u = 0; u < NUM_FU; u++) begin : g_u
        // R1
        grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(gnt[u]));
        // R2
        grant_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt[u] & ~req) == '0);
        // R4
        busy_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !fu_avail[u] |-> (gnt[u] == '0 && !vld[u]));
        // R7
        valid_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            vld[u] == (gnt[u] != '0));
    end

    // R6
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt[0] & gnt[NUM_FU-1]) == '0 || NUM_FU == 1);

    // R8
    pipe_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (gnt_q == $past(gnt) && vld_q == $past(vld)));

endmodule

bind issue_select_tree issue_select_tree_chk #(.WIN(WIN), .NUM_FU(NUM_FU)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .fu_avail (fu_avail),
    .gnt      (gnt),
    .vld      (vld),
    .gnt_q    (gnt_q),
    .vld_q    (vld_q)
);

// File: tb/tb_issue_select_tree.sv
module tb_issue_select_tree;

    localparam int unsigned WIN        = 32;
    localparam int unsigned NUM_FU     = 2;
    localparam time         CLK_PERIOD = 10ns;

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic [WIN-1:0]             req = '0;
    logic [NUM_FU-1:0]          fu_avail = '0;
    logic [NUM_FU-1:0][WIN-1:0] gnt;
    logic [NUM_FU-1:0]          vld;
    logic [NUM_FU-1:0][WIN-1:0] gnt_q;
    logic [NUM_FU-1:0]          vld_q;

    int checks   = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    issue_select_tree #(.WIN(WIN), .RADIX(4), .NUM_FU(NUM_FU)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .fu_avail(fu_avail),
        .gnt(gnt), .vld(vld), .gnt_q(gnt_q), .vld_q(vld_q)
    );

    function automatic logic [WIN-1:0] lowest(input logic [WIN-1:0] v);
        for (int i = 0; i < WIN; i++)
            if (v[i]) return WIN'(1) << i;
        return '0;
    endfunction

    task automatic check(input string tag, input logic [WIN-1:0] act,
                         input logic [WIN-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [WIN-1:0] r, input logic [NUM_FU-1:0] av);
        logic [NUM_FU-1:0][WIN-1:0] eg;
        logic [NUM_FU-1:0]          ev;
        logic [WIN-1:0]             open;
        @(negedge clk);
        req = r;
        fu_avail = av;
        open = r;
        for (int u = 0; u < NUM_FU; u++) begin
            eg[u] = av[u] ? lowest(open) : '0;
            ev[u] = (eg[u] != '0);
            open  = open & ~eg[u];
        end
        #1;
        for (int u = 0; u < NUM_FU; u++) begin
            // R3 (unit 0), R5 (unit 1), R4 busy unit, R9 empty request
            check(r == '0 ? "R9 grant" : (!av[u] ? "R4 grant" :
                  (u == 0 ? "R3 grant" : "R5 grant")), gnt[u], eg[u]);
            // R7
            check("R7 valid", WIN'(vld[u]), WIN'(ev[u]));
        end
        @(posedge clk);
        #1;
        for (int u = 0; u < NUM_FU; u++) begin
            // R8
            check("R8 gnt_q", gnt_q[u], eg[u]);
            check("R8 vld_q", WIN'(vld_q[u]), WIN'(ev[u]));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5e1ec7));
        req = '1;
        fu_avail = '1;
        repeat (3) @(posedge clk);
        #1;
        // R8 reset clears the registered copy
        check("R8 reset gnt_q0", gnt_q[0], '0);
        check("R8 reset gnt_q1", gnt_q[1], '0);
        check("R8 reset vld_q", WIN'(vld_q), '0);
        @(negedge clk);
        rst_n = 1'b1;

        // directed corners
        apply('0, 2'b11);                      // R9
        apply('1, 2'b11);                      // R3, R5
        apply(32'h8000_0000, 2'b11);           // single top slot
        apply(32'h0000_0018, 2'b11);           // slots 3 and 4, across leaves
        apply(32'h0001_8000, 2'b11);           // slots 15 and 16, across subtrees
        apply(32'hC000_0000, 2'b11);
        apply(32'h0000_00F0, 2'b10);           // R4 unit 0 busy, R5 lowest
        apply(32'h0000_00F0, 2'b01);           // R4 unit 1 busy
        apply(32'hFFFF_FFFF, 2'b00);           // R4 both busy
        apply(32'h0000_0001, 2'b11);           // only one request for two units

        // random patterns
        for (int k = 0; k < 3000; k++) begin
            logic [WIN-1:0] r;
            case (k % 3)
                0: r = $urandom();
                1: r = $urandom() & $urandom() & $urandom();
                default: r = $urandom() | $urandom();
            endcase
            apply(r, NUM_FU'($urandom()));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule